// File: doc/BRIEF.md
# One-Shot Prescaled Countdown Timer

This block is a 32-bit one-shot timer for a processor core's local interrupt logic. Software arms it by writing an initial count. The count then falls by one on every timer tick. A tick lasts a fixed sixteen core cycles multiplied by a power-of-two ratio. That ratio comes from a 4-bit divide configuration value.

The divide ratio is encoded oddly. Three of the four configuration bits form a code: bit 3 is the most significant, then bit 1, then bit 0. Bit 2 plays no part. The code plus one, taken modulo eight, gives the shift amount. So the all-ones code gives a ratio of one, and the all-zeros code gives a ratio of two.

The current count is visible at all times and reads as the number of whole ticks left before expiry. When the count reaches zero, the block raises a one-cycle expiry pulse and then stays idle until the next write.

Top module: `ltmr_core`

## Requirements
- R1: The tick shift is s = ({div_cfg_i[3], div_cfg_i[1], div_cfg_i[0]} + 1) mod 8, and the divide ratio is 2^s. div_cfg_i[2] has no effect.
- R2: One tick lasts 16 × 2^s core cycles.
- R3: A cycle with load_i high loads the low 32 bits of load_data_i; the upper bits are ignored. count_o shows the loaded value from the next cycle.
- R4: count_o never rises except through a load. It falls by exactly one at the end of each tick and reads as the number of whole ticks left.
- R5: After a nonzero load N, expire_o is high for exactly one cycle, 16 × 2^s × N clock edges after the load edge. That is the first cycle in which count_o reads zero.
- R6: Once at zero, count_o stays zero and expire_o stays low until the next load.
- R7: Loading zero stops any countdown in progress. count_o then reads zero and no expiry pulse follows.
- R8: A change to div_cfg_i during a tick does not change count_o or the length of that tick. It sets the length of the next tick.
- R9: A load during a countdown restarts it. The new count and a fresh full-length tick start from that load edge.
- R10: After reset, count_o is zero and expire_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Initial-count write strobe |
| load_data_i | input | 64 | Write data; only the low 32 bits are used |
| div_cfg_i | input | 4 | Divide configuration value |
| count_o | output | 32 | Whole ticks remaining |
| expire_o | output | 1 | One-cycle expiry pulse |

## Verification
The bench sweeps all sixteen configuration values and times each expiry against 16 × 2^s × N. A decoder that used the code without the increment, or that read bit 2, would expire at the wrong cycle for some of these values. The divider is also changed partway through a tick. A design that applied the new ratio at once, or that reset the count, would move the expiry edge. A reload in the middle of a tick catches a prescaler whose phase survives a reload. A zero load during a countdown catches a design that still pulses. Writing data with nonzero upper bits exposes any truncation fault.

// File: rtl/ltmr_pkg.sv
package ltmr_pkg;
    localparam int unsigned CFG_W   = 4;
    localparam int unsigned SHIFT_W = 3;

    typedef logic [SHIFT_W-1:0] shift_t;
    typedef logic [CFG_W-1:0]   cfg_t;
endpackage

// File: rtl/ltmr_div_decode.sv
module ltmr_div_decode
    import ltmr_pkg::*;
(
    input  cfg_t   cfg_i,
    output shift_t shift_o
);
    shift_t code;
    logic   unused_cfg;

    // Bit 2 sits outside the ratio code.
    assign unused_cfg = cfg_i[2];

    always_comb begin
        code    = {cfg_i[3], cfg_i[1], cfg_i[0]};
        shift_o = code + shift_t'(1);
    end
endmodule

// File: rtl/ltmr_prescale.sv
module ltmr_prescale
    import ltmr_pkg::*;
#(
    parameter int unsigned BASE_LOG2 = 4
) (
    input  logic   clk_i,
    input  logic   rst_ni,
    input  logic   restart_i,
    input  logic   run_i,
    input  shift_t shift_i,
    output logic   tick_o
);
    localparam int unsigned MAX_SHIFT = (1 << SHIFT_W) - 1;
    localparam int unsigned PRE_W     = BASE_LOG2 + MAX_SHIFT;

    logic [PRE_W-1:0] phase_d, phase_q;
    logic [PRE_W-1:0] last;

    always_comb begin
        // Last phase of the tick: 2^(BASE_LOG2 + shift) - 1.
        last    = {PRE_W{1'b1}} >> (PRE_W'(MAX_SHIFT) - PRE_W'(shift_i));
        tick_o  = run_i && !restart_i && (phase_q == last);
        phase_d = phase_q;
        if (restart_i || tick_o) begin
            phase_d = '0;
        end else if (run_i) begin
            phase_d = phase_q + PRE_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_d;
        end
    end
endmodule

// File: rtl/ltmr_core.sv
module ltmr_core
    import ltmr_pkg::*;
#(
    parameter int unsigned CNT_W     = 32,
    parameter int unsigned WDATA_W   = 64,
    parameter int unsigned BASE_LOG2 = 4
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               load_i,
    input  logic [WDATA_W-1:0] load_data_i,
    input  logic [CFG_W-1:0]   div_cfg_i,
    output logic [CNT_W-1:0]   count_o,
    output logic               expire_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        shift_t           shift;
        logic             expire;
    } state_t;

    state_t st_d, st_q;
    shift_t cfg_shift;
    logic   tick;
    logic   running;
    logic   unused_hi;

    assign unused_hi = ^load_data_i[WDATA_W-1:CNT_W];
    assign running   = (st_q.cnt != '0);

    ltmr_div_decode u_decode (
        .cfg_i   (div_cfg_i),
        .shift_o (cfg_shift)
    );

    ltmr_prescale #(
        .BASE_LOG2 (BASE_LOG2)
    ) u_prescale (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (load_i),
        .run_i     (running),
        .shift_i   (st_q.shift),
        .tick_o    (tick)
    );

    always_comb begin
        st_d        = st_q;
        st_d.expire = 1'b0;
        if (load_i) begin
            st_d.cnt   = load_data_i[CNT_W-1:0];
            st_d.shift = cfg_shift;
        end else if (tick) begin
            st_d.cnt    = st_q.cnt - CNT_W'(1);
            st_d.shift  = cfg_shift;
            st_d.expire = (st_q.cnt == CNT_W'(1));
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o  = st_q.cnt;
    assign expire_o = st_q.expire;
endmodule

// File: rtl/ltmr_core_chk.sv
module ltmr_core_chk #(
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned WDATA_W = 64
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               load_i,
    input logic [WDATA_W-1:0] load_data_i,
    input logic [CNT_W-1:0]   count_o,
    input logic               expire_o
);
    assert_load_value_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> count_o == $past(load_data_i[CNT_W-1:0]));

    assert_step_one_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_i |=> (count_o == $past(count_o)) || (count_o == $past(count_o) - CNT_W'(1)));

    assert_pulse_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        expire_o |=> !expire_o);

    assert_pulse_at_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        expire_o |-> count_o == '0);

    assert_expire_on_reach_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && count_o != '0) |=> ((count_o == '0) == expire_o));

    assert_hold_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && count_o == '0) |=> (count_o == '0 && !expire_o));

    assert_zero_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_i && load_data_i[CNT_W-1:0] == '0) |=> (count_o == '0 && !expire_o));
endmodule

bind ltmr_core ltmr_core_chk #(
    .CNT_W   (CNT_W),
    .WDATA_W (WDATA_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load_i),
    .load_data_i (load_data_i),
    .count_o     (count_o),
    .expire_o    (expire_o)
);

// File: tb/tb_ltmr_core.sv
module tb_ltmr_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic [63:0] wdata = '0;
    logic [3:0]  cfg = 4'b1011;
    logic [31:0] count;
    logic        expire;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    // Reference model state
    longint ref_cnt = 0;
    longint ref_phase = 0;
    longint ref_len = 16;
    bit     ref_exp = 1'b0;

    always #4 clk = ~clk;

    ltmr_core dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .load_i      (load),
        .load_data_i (wdata),
        .div_cfg_i   (cfg),
        .count_o     (count),
        .expire_o    (expire)
    );

    function automatic longint tick_len(input logic [3:0] c);
        int code;
        code = c[3] * 4 + c[1] * 2 + c[0];
        return 16 * (longint'(1) << ((code + 1) % 8));
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            ref_cnt = 0; ref_phase = 0; ref_exp = 1'b0; ref_len = tick_len(cfg);
        end else begin
            ref_exp = 1'b0;
            if (load) begin
                ref_cnt = longint'(wdata[31:0]);
                ref_phase = 0;
                ref_len = tick_len(cfg);
            end else if (ref_cnt != 0) begin
                ref_phase++;
                if (ref_phase == ref_len) begin
                    ref_phase = 0;
                    ref_cnt--;
                    ref_len = tick_len(cfg);
                    if (ref_cnt == 0) ref_exp = 1'b1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(longint'(count) == ref_cnt, "R4 model count", longint'(count), ref_cnt);
            check(expire == ref_exp, "R5 model expiry", longint'(expire), longint'(ref_exp));
        end
    end

    task automatic do_load(input logic [63:0] v, input logic [3:0] c);
        @(negedge clk);
        load = 1'b1; wdata = v; cfg = c;
        @(negedge clk);
        load = 1'b0;
    endtask

    // Counts edges after the load edge until expiry is visible.
    task automatic wait_expire(output longint n);
        n = 0;
        while (!expire && n < 20000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        longint n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(count == 0, "R10 reset count", longint'(count), 0);
        check(expire == 1'b0, "R10 reset expiry", longint'(expire), 0);

        // R1 R2 R5: every configuration value, count of 2
        for (int c = 0; c < 16; c++) begin
            do_load(64'd2, 4'(c));
            wait_expire(n);
            check(n == 2 * tick_len(4'(c)), "R1 R2 R5 expiry time", n, 2 * tick_len(4'(c)));
        end

        // R6: stays at zero after expiry
        repeat (50) @(negedge clk);
        check(count == 0 && !expire, "R6 hold zero", longint'(count), 0);

        // R3: upper data bits ignored
        do_load(64'hDEAD_BEEF_0000_0005, 4'b1011);
        check(count == 5, "R3 low bits loaded", longint'(count), 5);
        wait_expire(n);
        check(n == 80, "R3 R5 expiry of truncated load", n, 80);

        // R8: divider change mid-tick
        do_load(64'd2, 4'b1011);
        repeat (5) @(negedge clk);
        cfg = 4'b0000;
        @(negedge clk);
        check(count == 2, "R8 count unchanged by cfg", longint'(count), 2);
        n = 6;
        while (!expire && n < 20000) begin @(negedge clk); n++; end
        check(n == 16 + 32, "R8 ratio at next tick", n, 48);

        // R9: reload mid-tick restarts phase
        do_load(64'd3, 4'b1011);
        repeat (10) @(negedge clk);
        do_load(64'd1, 4'b1011);
        wait_expire(n);
        check(n == 16, "R9 restart on reload", n, 16);

        // R7: zero load stops countdown
        do_load(64'd4, 4'b1011);
        repeat (20) @(negedge clk);
        do_load(64'h1_0000_0000, 4'b1011);
        check(count == 0, "R7 zero load count", longint'(count), 0);
        n = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (expire) n++;
        end
        check(n == 0, "R7 no expiry", n, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule